// File: doc/BRIEF.md
# Dual-Section Phase Detector with Lock Detect

This block compares a reference pulse train against a divided pulse train in each of several independent synthesizer sections. All sections share one oscillator clock, which times the phase error. For every section it issues up and down pump commands and a tri-state enable with a drive value whose sign follows a per-section polarity bit. Pump current and the analog drivers sit outside the block.

Phase error is the number of oscillator clocks between the two edges. The error is the same whichever train arrives first, so it covers a full cycle of lead or lag. A per-section lock flag drops as soon as the error reaches an unlock count. It rises again only after several consecutive comparisons stay at or under a smaller lock count.

An active-low power-save input per section silences the pump and clears the section's state. On release the section re-aligns on the first pair of edges and then clips its drive for a few comparisons. A single shared monitor output carries either the combined lock state or one chosen raw pulse train.

Top module: `dual_pfd_lock`

## Requirements
- R1: After reset every section has up_o, dn_o, pump_en_o and lock_o low, and with mon_en_i low mon_o is low while any section is powered and unlocked.
- R2: A rising edge on fr_i raises up_o and a rising edge on fp_i raises dn_o. For a lead of k clocks the single-sided command lasts k cycles and pump_en_o is high for exactly those cycles. pump_dat_o equals up_o when pol_i is 1 and dn_o when pol_i is 0, so with pol_i=1 a leading fr_i drives 1 and a leading fp_i drives 0, and pol_i=0 swaps them.
- R3: Every comparison ends with up_o and dn_o both high for RST_PW cycles, with pump_en_o low, including at zero phase error.
- R4: lock_o rises at the end of the LOCK_CYC-th consecutive comparison whose error is at most LOCK_TH clocks. A comparison with a larger error restarts the count.
- R5: lock_o falls, and the good-comparison count clears, once an open comparison has lasted UNLOCK_TH clocks.
- R6: While psave_ni of a section is 0, its up_o, dn_o and pump_en_o are 0 in the same cycle, and its lock_o is 0 from the next cycle.
- R7: With mon_en_i = 0, mon_o is 1 exactly when every section is locked or has psave_ni = 0.
- R8: After reset or power-save release, a section issues no drive until it has seen one fr_i edge and one fp_i edge. Those edges are consumed and start no comparison.
- R9: During the first LIMIT_CMP comparisons after arming, a single-sided command lasts at most CLIP_W cycles.
- R10: With mon_en_i = 1, mon_o follows the input selected by mon_sel_i. Bit 0 of mon_sel_i picks the section, and the top bit picks fr_i (0) or fp_i (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | oscillator clock that times the phase error |
| rst_ni | input | 1 | active-low asynchronous reset |
| fr_i | input | NUM_SECT | reference pulse train per section |
| fp_i | input | NUM_SECT | divided pulse train per section |
| pol_i | input | NUM_SECT | drive polarity per section |
| psave_ni | input | NUM_SECT | active-low power save per section |
| mon_en_i | input | 1 | 1 selects a raw pulse train on mon_o, 0 selects combined lock |
| mon_sel_i | input | SEL_W | pulse train select: low bits section, top bit fr/fp |
| up_o | output | NUM_SECT | up pump command |
| dn_o | output | NUM_SECT | down pump command |
| pump_en_o | output | NUM_SECT | pump drive enable, 0 means high impedance |
| pump_dat_o | output | NUM_SECT | pump drive level when enabled |
| lock_o | output | NUM_SECT | per-section lock flag |
| mon_o | output | 1 | shared monitor output |

## Verification
The bench uses the default thresholds: unlock at 3 clocks, lock at 2 clocks after 3 good comparisons, and a one-cycle overlap. It lowers LIMIT_CMP to 2 so that the end of the clipping window is reached after a few comparisons. This lets one section go through arming, two clipped 5-clock comparisons and then an unclipped one. It then exercises the exact lock and unlock boundaries, both polarities, and a power-save cycle. Two sections are enough to cover every monitor select code and every combination of locked and power-saved sections that feeds the combined lock.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  typedef enum logic {
    PH_ARM = 1'b0,
    PH_RUN = 1'b1
  } phase_e;
endpackage

// File: rtl/pdl_pfd_core.sv
module pdl_pfd_core
  import pdl_pkg::*;
#(
  parameter int ERR_W     = 8,
  parameter int RST_PW    = 1,
  parameter int LIMIT_CMP = 4,
  parameter int CLIP_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fr_i,
  input  logic             fp_i,
  input  logic             pol_i,
  input  logic             psave_ni,
  output logic             up_o,
  output logic             dn_o,
  output logic             pump_en_o,
  output logic             pump_dat_o,
  output logic             cmp_evt_o,
  output logic             busy_o,
  output logic [ERR_W-1:0] err_o
);
  localparam int OV_W  = $clog2(RST_PW + 1);
  localparam int LIM_W = $clog2(LIMIT_CMP + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [ERR_W-1:0] CLIP_V  = ERR_W'(CLIP_W);
  localparam logic [OV_W-1:0]  OV_LAST = OV_W'(RST_PW - 1);
  localparam logic [LIM_W-1:0] LIM_END = LIM_W'(LIMIT_CMP);

  phase_e ph_q;
  logic fr_q, fp_q, fr_edge, fp_edge;
  logic fr_seen_q, fp_seen_q;
  logic up_q, dn_q, both, clr, arm_done, lim_act, clip;
  logic [ERR_W-1:0] err_q;
  logic [OV_W-1:0]  ov_q;
  logic [LIM_W-1:0] lim_q;

  assign fr_edge  = fr_i & ~fr_q;
  assign fp_edge  = fp_i & ~fp_q;
  assign both     = up_q & dn_q;
  assign clr      = both && (ov_q == OV_LAST);
  assign arm_done = (ph_q == PH_ARM) && (fr_seen_q || fr_edge) && (fp_seen_q || fp_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q <= 1'b0;
      fp_q <= 1'b0;
    end else begin
      fr_q <= fr_i;
      fp_q <= fp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_ARM;
      fr_seen_q <= 1'b0;
      fp_seen_q <= 1'b0;
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      err_q     <= '0;
      ov_q      <= '0;
      lim_q     <= '0;
    end else if (!psave_ni) begin
      ph_q      <= PH_ARM;
      fr_seen_q <= 1'b0;
      fp_seen_q <= 1'b0;
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      err_q     <= '0;
      ov_q      <= '0;
      lim_q     <= '0;
    end else if (ph_q == PH_ARM) begin
      // realign: the first edge pair is consumed without drive
      if (arm_done) begin
        ph_q      <= PH_RUN;
        fr_seen_q <= 1'b0;
        fp_seen_q <= 1'b0;
        lim_q     <= '0;
      end else begin
        fr_seen_q <= fr_seen_q | fr_edge;
        fp_seen_q <= fp_seen_q | fp_edge;
      end
    end else begin
      up_q <= (up_q & ~clr) | fr_edge;
      dn_q <= (dn_q & ~clr) | fp_edge;
      if (both) begin
        ov_q <= clr ? '0 : ov_q + 1'b1;
      end else begin
        ov_q <= '0;
      end
      if (both) begin
        err_q <= err_q;
      end else if (up_q ^ dn_q) begin
        err_q <= (err_q == ERR_MAX) ? err_q : err_q + 1'b1;
      end else begin
        err_q <= '0;
      end
      if (cmp_evt_o && (lim_q != LIM_END)) lim_q <= lim_q + 1'b1;
    end
  end

  assign cmp_evt_o  = both && (ov_q == '0);
  assign lim_act    = (ph_q == PH_RUN) && (lim_q != LIM_END);
  assign clip       = lim_act && (up_q ^ dn_q) && (err_q >= CLIP_V);
  assign up_o       = psave_ni & up_q & ~clip;
  assign dn_o       = psave_ni & dn_q & ~clip;
  assign pump_en_o  = up_o ^ dn_o;
  assign pump_dat_o = pol_i ? up_o : dn_o;
  assign busy_o     = up_q | dn_q;
  assign err_o      = err_q;

  a_r6_ps_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psave_ni |-> (!up_o && !dn_o && !pump_en_o));
  a_r6_ps_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psave_ni |=> (ph_q == PH_ARM));
  a_r8_arm_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_ARM) |-> (!up_q && !dn_q));
  a_r3_overlap_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both |-> (ov_q < OV_W'(RST_PW)));
  a_r9_clip_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_act && pump_en_o) |-> (err_q < CLIP_V));
endmodule

// File: rtl/pdl_lock_det.sv
module pdl_lock_det #(
  parameter int ERR_W     = 8,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_TH   = 2,
  parameter int LOCK_CYC  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psave_ni,
  input  logic             cmp_evt_i,
  input  logic             busy_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             lock_o
);
  localparam int GOOD_W = $clog2(LOCK_CYC + 1);
  localparam logic [ERR_W-1:0]  UNLOCK_V = ERR_W'(UNLOCK_TH);
  localparam logic [ERR_W-1:0]  LOCK_V   = ERR_W'(LOCK_TH);
  localparam logic [GOOD_W-1:0] GOOD_END = GOOD_W'(LOCK_CYC);

  logic [GOOD_W-1:0] good_q, good_nx;
  logic lock_q, unlock_hit;

  assign unlock_hit = busy_i && (err_i >= UNLOCK_V);
  assign good_nx    = (good_q == GOOD_END) ? good_q : good_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (!psave_ni || unlock_hit) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (cmp_evt_i) begin
      if (err_i <= LOCK_V) begin
        good_q <= good_nx;
        if (good_nx == GOOD_END) lock_q <= 1'b1;
      end else begin
        good_q <= '0;
      end
    end
  end

  assign lock_o = lock_q;

  a_r4_rise_on_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(cmp_evt_i && (err_i <= LOCK_V) && psave_ni));
  a_r5_drop_on_big: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (err_i >= UNLOCK_V)) |=> !lock_q);
  a_r6_ps_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psave_ni |=> !lock_q);
endmodule

// File: rtl/pdl_mon_mux.sv
module pdl_mon_mux #(
  parameter int NUM_SECT = 2,
  parameter int SEL_W    = 2
) (
  input  logic [NUM_SECT-1:0] fr_i,
  input  logic [NUM_SECT-1:0] fp_i,
  input  logic [NUM_SECT-1:0] lock_i,
  input  logic [NUM_SECT-1:0] psave_ni,
  input  logic                mon_en_i,
  input  logic [SEL_W-1:0]    mon_sel_i,
  output logic                mon_o
);
  localparam int IDX_W = SEL_W - 1;

  logic [IDX_W-1:0] idx;
  logic lock_all, raw;

  assign idx      = mon_sel_i[IDX_W-1:0];
  assign lock_all = &(lock_i | ~psave_ni);

  always_comb begin
    raw = 1'b0;
    for (int s = 0; s < NUM_SECT; s++) begin
      if (idx == IDX_W'(s)) raw = mon_sel_i[SEL_W-1] ? fp_i[s] : fr_i[s];
    end
  end

  assign mon_o = mon_en_i ? raw : lock_all;
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
  parameter int NUM_SECT  = 2,
  parameter int ERR_W     = 8,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_TH   = 2,
  parameter int LOCK_CYC  = 3,
  parameter int RST_PW    = 1,
  parameter int LIMIT_CMP = 4,
  parameter int CLIP_W    = 2,
  localparam int SEL_W    = $clog2(NUM_SECT) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SECT-1:0] fr_i,
  input  logic [NUM_SECT-1:0] fp_i,
  input  logic [NUM_SECT-1:0] pol_i,
  input  logic [NUM_SECT-1:0] psave_ni,
  input  logic                mon_en_i,
  input  logic [SEL_W-1:0]    mon_sel_i,
  output logic [NUM_SECT-1:0] up_o,
  output logic [NUM_SECT-1:0] dn_o,
  output logic [NUM_SECT-1:0] pump_en_o,
  output logic [NUM_SECT-1:0] pump_dat_o,
  output logic [NUM_SECT-1:0] lock_o,
  output logic                mon_o
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic             cmp_evt, busy;
    logic [ERR_W-1:0] err;

    pdl_pfd_core #(
      .ERR_W(ERR_W), .RST_PW(RST_PW), .LIMIT_CMP(LIMIT_CMP), .CLIP_W(CLIP_W)
    ) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fr_i      (fr_i[s]),
      .fp_i      (fp_i[s]),
      .pol_i     (pol_i[s]),
      .psave_ni  (psave_ni[s]),
      .up_o      (up_o[s]),
      .dn_o      (dn_o[s]),
      .pump_en_o (pump_en_o[s]),
      .pump_dat_o(pump_dat_o[s]),
      .cmp_evt_o (cmp_evt),
      .busy_o    (busy),
      .err_o     (err)
    );

    pdl_lock_det #(
      .ERR_W(ERR_W), .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH), .LOCK_CYC(LOCK_CYC)
    ) u_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .psave_ni (psave_ni[s]),
      .cmp_evt_i(cmp_evt),
      .busy_i   (busy),
      .err_i    (err),
      .lock_o   (lock_o[s])
    );
  end

  pdl_mon_mux #(.NUM_SECT(NUM_SECT), .SEL_W(SEL_W)) u_mon (
    .fr_i     (fr_i),
    .fp_i     (fp_i),
    .lock_i   (lock_o),
    .psave_ni (psave_ni),
    .mon_en_i (mon_en_i),
    .mon_sel_i(mon_sel_i),
    .mon_o    (mon_o)
  );

  a_r7_all_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mon_en_i && (psave_ni == '0)) |-> mon_o);
  a_r7_any_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mon_en_i && ((lock_o | ~psave_ni) != '1)) |-> !mon_o);
endmodule

// File: tb/dual_pfd_lock_tb_top.sv
module dual_pfd_lock_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fr = '0, fp = '0, pol = 2'b11, psn = 2'b11, sel = '0;
  logic mon_en = 1'b0;
  logic [1:0] up, dn, en, dat, lock;
  logic mon;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_pfd_lock #(.LIMIT_CMP(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fr_i(fr), .fp_i(fp), .pol_i(pol), .psave_ni(psn),
    .mon_en_i(mon_en), .mon_sel_i(sel), .up_o(up), .dn_o(dn), .pump_en_o(en),
    .pump_dat_o(dat), .lock_o(lock), .mon_o(mon)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one comparison on section 0: leader pulses at c=0, follower at c=k
  task automatic cmp(bit fr_lead, int k, output int en_n, output int ov_n, output int d);
    en_n = 0; ov_n = 0; d = -1;
    for (int c = 0; c < k + 4; c++) begin
      @(negedge clk);
      if (en[0]) begin en_n++; d = int'(dat[0]); end
      if (up[0] && dn[0]) ov_n++;
      fr[0] = fr_lead ? (c == 0) : (c == k);
      fp[0] = fr_lead ? (c == k) : (c == 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 en", int'(en), 0);
    chk("R1 up/dn", int'(up | dn), 0);
    chk("R1 lock", int'(lock), 0);
    chk("R1 mon", int'(mon), 0);
  endtask

  task automatic t_arm_clip();
    int e, o, d;
    cmp(1, 2, e, o, d); chk("R8 arm no drive", e, 0); chk("R8 arm no overlap", o, 0);
    cmp(1, 5, e, o, d); chk("R9 clip 1st", e, 2);
    cmp(1, 5, e, o, d); chk("R9 clip 2nd", e, 2);
    cmp(1, 5, e, o, d); chk("R2 full width", e, 5); chk("R2 pol1 lead", d, 1);
    chk("R3 overlap", o, 1);
  endtask

  task automatic t_lock();
    int e, o, d;
    cmp(0, 2, e, o, d); chk("R2 pol1 lag", d, 0); chk("R2 lag width", e, 2);
    cmp(1, 3, e, o, d); chk("R5 unlock at 3", int'(lock[0]), 0);
    cmp(1, 2, e, o, d); cmp(1, 2, e, o, d); chk("R4 two good", int'(lock[0]), 0);
    cmp(1, 0, e, o, d); chk("R3 zero err no en", e, 0); chk("R3 zero err pulse", o, 1);
    chk("R4 third good", int'(lock[0]), 1);
    cmp(1, 4, e, o, d); chk("R5 drop", int'(lock[0]), 0);
    cmp(1, 2, e, o, d); cmp(1, 2, e, o, d); cmp(1, 3, e, o, d);
    cmp(1, 2, e, o, d); cmp(1, 2, e, o, d); chk("R4 count restarted", int'(lock[0]), 0);
    cmp(0, 2, e, o, d); chk("R4 relock", int'(lock[0]), 1);
  endtask

  task automatic t_pol();
    int e, o, d;
    pol[0] = 1'b0;
    cmp(1, 2, e, o, d); chk("R2 pol0 lead", d, 0); chk("R2 pol0 width", e, 2);
    cmp(0, 1, e, o, d); chk("R2 pol0 lag", d, 1);
    chk("R4 lock kept", int'(lock[0]), 1);
    pol[0] = 1'b1;
  endtask

  task automatic t_psave();
    int e, o, d;
    @(negedge clk); #1; chk("R7 s1 open", int'(mon), 0);
    psn[1] = 1'b0; #1; chk("R7 s1 saved", int'(mon), 1);
    @(negedge clk); psn[0] = 1'b0; #1;
    chk("R6 en same cycle", int'(en[0]), 0);
    chk("R7 both saved", int'(mon), 1);
    @(negedge clk); chk("R6 lock cleared", int'(lock[0]), 0);
    cmp(1, 3, e, o, d); chk("R6 no drive", e + o, 0);
    @(negedge clk); psn[0] = 1'b1; #1; chk("R7 s0 unlocked", int'(mon), 0);
    cmp(1, 2, e, o, d); chk("R8 rearm no drive", e, 0);
    cmp(1, 4, e, o, d); chk("R9 clip after restart", e, 2);
    // cut power mid pulse
    @(negedge clk); fr[0] = 1'b1;
    @(negedge clk); fr[0] = 1'b0; chk("R6 pulse open", int'(en[0]), 1);
    psn[0] = 1'b0; #1; chk("R6 pulse cut", int'(en[0]), 0);
  endtask

  task automatic t_mon();
    mon_en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      fr = '0; fp = '0;
      if (t[1]) fp[t[0]] = 1'b1; else fr[t[0]] = 1'b1;
      for (int s = 0; s < 4; s++) begin
        sel = 2'(s); #1;
        chk($sformatf("R10 sel %0d src %0d", s, t), int'(mon), int'(s == t));
      end
    end
    fr = '0; fp = '0; mon_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arm_clip();
    t_lock();
    t_pol();
    t_psave();
    t_mon();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule